// File: doc/BRIEF.md
# Saturating Packed-Integer Narrowing Unit

This unit accepts two 128-bit packed integer operands. It halves the width of every signed lane in both operands and clamps each value into the range of the narrower type. The narrowed lanes are combined into a single 128-bit result. A two-bit mode input picks the source lane width (16 or 32 bits) and whether the destination type is signed or unsigned. The result is available one clock after a qualified request.

The unit also returns one flag per output lane. A flag is set when that lane had to be clamped. This lets the surrounding pipeline, or a reference model, see exactly which lanes left their range. Lane 0 sits in the least significant bits of every vector. The lanes taken from operand A fill the low half of the result, and the lanes taken from operand B fill the high half.

Top module: `spk_pack_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `result` and `sat_flags` are cleared to zero at that edge.
- R2: Mode 2'b00 (signed 16 to signed 8): a source value below -128 gives 8'h80, a value above 127 gives 8'h7F, and any other value gives its low byte.
- R3: Mode 2'b10 (signed 32 to signed 16): a source value below -32768 gives 16'h8000, a value above 32767 gives 16'h7FFF, and any other value gives its low 16 bits.
- R4: Mode 2'b01 (signed 16 to unsigned 8): a negative source gives 8'h00, a source above 255 gives 8'hFF, and any other value gives its low byte.
- R5: Mode 2'b11 (signed 32 to unsigned 16): a negative source gives 16'h0000, a source above 65535 gives 16'hFFFF, and any other value gives its low 16 bits.
- R6: Source lane i of `op_a` becomes output lane i. Source lane i of `op_b` becomes output lane i + N, where N is the number of source lanes in one operand (8 for 16-bit sources, 4 for 32-bit sources). Output lane j occupies bits [j*W +: W], where W is the output lane width.
- R7: `sat_flags[j]` is 1 exactly when output lane j was clamped. Its meaning follows the output lane numbering of R6.
- R8: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R9: A clock edge with `in_valid` low leaves `result` and `sat_flags` unchanged.
- R10: In the 32-bit source modes (mode bit 1 set), `sat_flags[15:8]` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | Bit 1: source is 32-bit; bit 0: destination is unsigned |
| op_a | input | 128 | First packed operand, narrowed into the low half |
| op_b | input | 128 | Second packed operand, narrowed into the high half |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 128 | Packed, narrowed, clamped lanes |
| sat_flags | output | 16 | One clamp indicator per output lane |

## Verification
The assertions assume that `mode` is a stable two-bit value whenever `in_valid` is high. They relate the clamp codes only to lanes whose flag is set, so they expect the flags and the data to come from the same request. The stimulus keeps to this by changing mode and operands only on the falling edge, together with `in_valid`. In the 16-bit modes, every one of the 65536 source values passes through a lane. In the 32-bit modes, the lanes carry values placed just around each clamp threshold, mixed with scattered large magnitudes of both signs.

// File: rtl/spk_pkg.sv
package spk_pkg;
   typedef enum logic [1:0] {
      PK_S16_S8  = 2'b00,
      PK_S16_U8  = 2'b01,
      PK_S32_S16 = 2'b10,
      PK_S32_U16 = 2'b11
   } pk_mode_e;
endpackage

// File: rtl/spk_lane.sv
module spk_lane #(
   parameter int SRC_W = 16
) (
   input  logic [SRC_W-1:0]   src,
   input  logic               to_unsigned,
   output logic [SRC_W/2-1:0] dst,
   output logic               clamped
);
   localparam int DST_W = SRC_W / 2;

   logic neg;
   logic sign_mix;
   logic upper_set;

   always_comb begin
      neg       = src[SRC_W-1];
      // the value fits a signed DST_W lane only if these bits all match the sign
      sign_mix  = (src[SRC_W-1:DST_W-1] != {(DST_W+1){neg}});
      upper_set = |src[SRC_W-2:DST_W];
      if (to_unsigned) begin
         if (neg) begin
            dst     = '0;
            clamped = 1'b1;
         end else if (upper_set) begin
            dst     = '1;
            clamped = 1'b1;
         end else begin
            dst     = src[DST_W-1:0];
            clamped = 1'b0;
         end
      end else if (sign_mix) begin
         dst     = {neg, {(DST_W-1){~neg}}};
         clamped = 1'b1;
      end else begin
         dst     = src[DST_W-1:0];
         clamped = 1'b0;
      end
   end
endmodule

// File: rtl/spk_half.sv
module spk_half #(
   parameter int SRC_W  = 16,
   parameter int DATA_W = 128
) (
   input  logic [DATA_W-1:0]       opnd,
   input  logic                    to_unsigned,
   output logic [DATA_W/2-1:0]     narrow_o,
   output logic [DATA_W/SRC_W-1:0] clamp_o
);
   localparam int NLANE = DATA_W / SRC_W;
   localparam int DST_W = SRC_W / 2;

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      spk_lane #(.SRC_W(SRC_W)) u_lane (
         .src        (opnd[i*SRC_W +: SRC_W]),
         .to_unsigned(to_unsigned),
         .dst        (narrow_o[i*DST_W +: DST_W]),
         .clamped    (clamp_o[i])
      );
   end
endmodule

// File: rtl/spk_pack_unit.sv
module spk_pack_unit #(
   parameter int DATA_W = 128
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [1:0]          mode,
   input  logic [DATA_W-1:0]   op_a,
   input  logic [DATA_W-1:0]   op_b,
   output logic                out_valid,
   output logic [DATA_W-1:0]   result,
   output logic [DATA_W/8-1:0] sat_flags
);
   localparam int HALF   = DATA_W / 2;
   localparam int FLAG_W = DATA_W / 8;
   localparam int NSRC   = 2;

   if (DATA_W % 32 != 0 || DATA_W < 32) begin : g_bad_width
      $error("spk_pack_unit: DATA_W must be a positive multiple of 32");
   end

   logic [DATA_W-1:0] cand_res  [NSRC];
   logic [FLAG_W-1:0] cand_flag [NSRC];

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      localparam int SW = 16 << k;
      localparam int NL = DATA_W / SW;
      logic [HALF-1:0] lo_half, hi_half;
      logic [NL-1:0]   fa, fb;

      spk_half #(.SRC_W(SW), .DATA_W(DATA_W)) u_a (
         .opnd(op_a), .to_unsigned(mode[0]), .narrow_o(lo_half), .clamp_o(fa)
      );
      spk_half #(.SRC_W(SW), .DATA_W(DATA_W)) u_b (
         .opnd(op_b), .to_unsigned(mode[0]), .narrow_o(hi_half), .clamp_o(fb)
      );

      assign cand_res[k]  = {hi_half, lo_half};
      assign cand_flag[k] = FLAG_W'({fb, fa});
   end

   logic [DATA_W-1:0] next_res;
   logic [FLAG_W-1:0] next_flag;

   always_comb begin
      next_res  = cand_res[mode[1]];
      next_flag = cand_flag[mode[1]];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
         sat_flags <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= next_res;
            sat_flags <= next_flag;
         end
      end
   end
endmodule

// File: rtl/spk_pack_unit_chk.sv
module spk_pack_unit_chk #(
   parameter int DATA_W = 128
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [1:0]          mode,
   input logic [DATA_W-1:0]   result,
   input logic [DATA_W/8-1:0] sat_flags,
   input logic                out_valid
);
   import spk_pkg::*;
   localparam int FLAG_W = DATA_W / 8;

   logic s8_codes_ok, u8_codes_ok;

   always_comb begin
      s8_codes_ok = 1'b1;
      u8_codes_ok = 1'b1;
      for (int i = 0; i < FLAG_W; i++) begin
         if (sat_flags[i] && result[i*8 +: 8] != 8'h80 && result[i*8 +: 8] != 8'h7F)
            s8_codes_ok = 1'b0;
         if (sat_flags[i] && result[i*8 +: 8] != 8'h00 && result[i*8 +: 8] != 8'hFF)
            u8_codes_ok = 1'b0;
      end
   end

   AST_VALID_RISE:   assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R8
   AST_VALID_DROP:   assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R8
   AST_IDLE_HOLD:    assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(result) && $stable(sat_flags))); // R9
   AST_S8_CLAMP:     assert property (@(posedge clk) disable iff (rst) (in_valid && mode == PK_S16_S8) |=> s8_codes_ok); // R2
   AST_U8_CLAMP:     assert property (@(posedge clk) disable iff (rst) (in_valid && mode == PK_S16_U8) |=> u8_codes_ok); // R4
   AST_WIDE_FLAGS:   assert property (@(posedge clk) disable iff (rst) (in_valid && mode[1]) |=> (sat_flags[FLAG_W-1:FLAG_W/2] == '0)); // R10
endmodule

bind spk_pack_unit spk_pack_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
   .result(result), .sat_flags(sat_flags), .out_valid(out_valid)
);

// File: tb/spk_pack_unit_test.sv
module spk_pack_unit_test;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [1:0]   mode;
   logic [127:0] op_a, op_b;
   logic         out_valid;
   logic [127:0] result;
   logic [15:0]  sat_flags;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #10 clk = ~clk;

   spk_pack_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
      .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
      .result(result), .sat_flags(sat_flags)
   );

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // Reference: clamp by arithmetic comparison on integer values
   task automatic model(input int m, input logic [127:0] a, input logic [127:0] b,
                        output logic [127:0] er, output logic [15:0] ef);
      er = '0;
      ef = '0;
      if (m < 2) begin
         for (int l = 0; l < 16; l++) begin
            logic [15:0] s;
            int v;
            s = (l < 8) ? a[l*16 +: 16] : b[(l-8)*16 +: 16];
            v = $signed(s);
            if (m == 0) begin
               if (v < -128)     begin er[l*8 +: 8] = 8'h80; ef[l] = 1'b1; end
               else if (v > 127) begin er[l*8 +: 8] = 8'h7F; ef[l] = 1'b1; end
               else er[l*8 +: 8] = s[7:0];
            end else begin
               if (v < 0)        begin er[l*8 +: 8] = 8'h00; ef[l] = 1'b1; end
               else if (v > 255) begin er[l*8 +: 8] = 8'hFF; ef[l] = 1'b1; end
               else er[l*8 +: 8] = s[7:0];
            end
         end
      end else begin
         for (int l = 0; l < 8; l++) begin
            logic [31:0] s;
            longint v;
            s = (l < 4) ? a[l*32 +: 32] : b[(l-4)*32 +: 32];
            v = longint'($signed(s));
            if (m == 2) begin
               if (v < -32768)     begin er[l*16 +: 16] = 16'h8000; ef[l] = 1'b1; end
               else if (v > 32767) begin er[l*16 +: 16] = 16'h7FFF; ef[l] = 1'b1; end
               else er[l*16 +: 16] = s[15:0];
            end else begin
               if (v < 0)          begin er[l*16 +: 16] = 16'h0000; ef[l] = 1'b1; end
               else if (v > 65535) begin er[l*16 +: 16] = 16'hFFFF; ef[l] = 1'b1; end
               else er[l*16 +: 16] = s[15:0];
            end
         end
      end
   endtask

   function automatic logic [31:0] gen32(input int idx);
      int base;
      if (idx < 64) begin
         case (idx % 16)
            0: base = 0;        1: base = -1;       2: base = 1;       3: base = 127;
            4: base = 128;      5: base = -128;     6: base = -129;    7: base = 255;
            8: base = 256;      9: base = 32767;    10: base = 32768;  11: base = -32768;
            12: base = -32769;  13: base = 65535;   14: base = 65536;  default: base = 32'h7FFFFFFE;
         endcase
         return 32'(base + idx / 16 - 1);
      end
      return 32'($signed(32'(idx) * 32'h9E3779B1) >>> (idx % 24));
   endfunction

   task automatic run_vec(input int m, input logic [127:0] a, input logic [127:0] b);
      logic [127:0] er;
      logic [15:0]  ef;
      string tag;
      model(m, a, b, er, ef);
      case (m)
         0: tag = "R2/R6 s16->s8";
         1: tag = "R4/R6 s16->u8";
         2: tag = "R3/R6 s32->s16";
         default: tag = "R5/R6 s32->u16";
      endcase
      @(negedge clk);
      in_valid = 1'b1;
      mode     = 2'(m);
      op_a     = a;
      op_b     = b;
      @(negedge clk);
      check(tag, result, er);
      check((m >= 2) ? "R7/R10 flags" : "R7 flags", 128'(sat_flags), 128'(ef));
      check("R8 out_valid", 128'(out_valid), 128'(1));
   endtask

   initial begin
      logic [127:0] a, b, held_r;
      logic [15:0]  held_f;
      rst = 1'b1; in_valid = 1'b0; mode = 2'b00; op_a = '1; op_b = '1;
      repeat (3) @(negedge clk);
      check("R1 out_valid reset", 128'(out_valid), 128'(0));
      check("R1 result reset", result, '0);
      check("R1 flags reset", 128'(sat_flags), '0);
      rst = 1'b0;

      // 16-bit source modes: every source value through a lane
      for (int m = 0; m < 2; m++) begin
         for (int v = 0; v < 4096; v++) begin
            for (int l = 0; l < 8; l++) begin
               a[l*16 +: 16] = 16'(v*16 + l);
               b[l*16 +: 16] = 16'(v*16 + l + 8);
            end
            run_vec(m, a, b);
         end
      end

      // 32-bit source modes: threshold neighbourhoods and scattered values
      for (int m = 2; m < 4; m++) begin
         for (int v = 0; v < 128; v++) begin
            for (int l = 0; l < 4; l++) begin
               a[l*32 +: 32] = gen32(v*8 + l);
               b[l*32 +: 32] = gen32(v*8 + l + 4);
            end
            run_vec(m, a, b);
         end
      end

      // R9: idle cycles keep the registered result; R8: valid drops one cycle later
      run_vec(0, {8{16'h8123}}, {8{16'h0042}});
      held_r = result;
      held_f = sat_flags;
      @(negedge clk);
      in_valid = 1'b0; mode = 2'b11; op_a = '0; op_b = {4{32'h0001_0000}};
      @(negedge clk);
      check("R8 out_valid low", 128'(out_valid), 128'(0));
      check("R9 result held", result, held_r);
      @(negedge clk);
      check("R9 flags held", 128'(sat_flags), 128'(held_f));

      // R1: reset mid-run clears the registers
      run_vec(1, {8{16'hFFFF}}, {8{16'h0100}});
      rst = 1'b1;
      @(negedge clk);
      check("R1 result cleared", result, '0);
      check("R1 valid cleared", 128'(out_valid), 128'(0));
      rst = 1'b0;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end
endmodule